// File: doc/BRIEF.md
# Single-Step Halt Controller

This block lets an external debug input walk a small processor through its program one instruction at a time. An active-low step request is brought through a synchronizer. It is looked at only while the machine-cycle strobe from the timing generator is high. Once a low level is seen in that window, the controller waits for the core to finish its next instruction fetch and then freezes the core with a stall output.

While the core is frozen, the address output switches from the core's own address to the address of the next instruction. This lets an external observer read where execution will resume. Each time the step request is taken high for at least one strobe window, the core is released. After it completes one more fetch, it halts again if the request has gone back low. If the request has stayed high, it returns to free running. The controller behaves the same way in every operating mode of the processor, because it uses only the strobe, the fetch-done pulse and the step request.

Top module: `step_halt_ctrl`

## Requirements
- R1: During and right after reset the controller is free running: `stall` is 0 and `disp_addr` equals `core_addr`. The synchronizer stages reset to the released (high) level.
- R2: `step_n` passes through two flip-flops before use. A change applied before clock edge k can affect the state no earlier than edge k+2.
- R3: While `cyc_strobe` is 0, the synchronized step level has no effect on the state. This holds in the running state and in the halted state.
- R4: In the running state, a low step level seen while `cyc_strobe` is 1 arms a pending halt. `stall` stays 0 while the halt is pending.
- R5: From a pending halt, a `fetch_done` pulse makes `stall` 1 from the next clock edge onward. `stall` only ever rises on the edge after a cycle with `fetch_done` set.
- R6: A pending halt is withdrawn, back to free running, if a high step level is seen while `cyc_strobe` is 1 and `fetch_done` is 0 in that cycle.
- R7: When a pending halt sees `fetch_done` and a high step level under `cyc_strobe` in the same cycle, the fetch wins and the controller halts.
- R8: When halted, a high step level seen while `cyc_strobe` is 1 drops `stall` on the next edge. `fetch_done` has no effect while halted.
- R9: After a release, exactly one `fetch_done` is allowed through. On it, the controller halts again if the most recent strobe-window level is low, and runs freely if it is high. A strobe in the same cycle as that fetch supplies the level.
- R10: `disp_addr` equals `pc_next` whenever `stall` is 1, and `core_addr` otherwise.
- R11: `fetch_done` has no effect in the free-running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_n | input | 1 | Asynchronous step request, low = stop |
| cyc_strobe | input | 1 | Machine-cycle strobe from the timing generator; step level is sampled only while high |
| fetch_done | input | 1 | One-cycle pulse from the core when an instruction fetch completes |
| pc_next | input | ADDR_W | Address of the next instruction to fetch |
| core_addr | input | ADDR_W | Address the core drives when not halted |
| stall | output | 1 | Freezes the core while 1 |
| disp_addr | output | ADDR_W | Address presented on the external bus and upper port nibble |

## Verification
Two events can land in the same cycle: the fetch-completion pulse, and a strobe-window sample of the step level. The bench arranges both for a pending halt whose request has just been released. The required outcome is a halt, because the fetch has priority. It also arranges both for a stepping core whose request stays high, where the required outcome is free running because the same-cycle sample decides. In each case `stall` and `disp_addr` are read one edge later. The value is judged against the table entry derived from the requirements.

// File: rtl/step_halt_pkg.sv
package step_halt_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_PENDING = 2'd1,
        ST_HALTED  = 2'd2,
        ST_STEP    = 2'd3
    } halt_state_e;

    typedef struct packed {
        halt_state_e state;
        logic        lvl_lat;
    } halt_regs_t;

endpackage

// File: rtl/shc_sync.sv
module shc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/shc_fsm.sv
module shc_fsm
    import step_halt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic strobe,
    input  logic fetch_done,
    output logic halted
);
    halt_regs_t r_d, r_q;
    logic       eff_lvl;

    always_comb begin
        r_d     = r_q;
        eff_lvl = strobe ? lvl : r_q.lvl_lat;
        if (strobe) r_d.lvl_lat = lvl;
        case (r_q.state)
            ST_RUN: begin
                if (strobe && !lvl) r_d.state = ST_PENDING;
            end
            ST_PENDING: begin
                if (fetch_done)         r_d.state = ST_HALTED;
                else if (strobe && lvl) r_d.state = ST_RUN;
            end
            ST_HALTED: begin
                if (strobe && lvl) r_d.state = ST_STEP;
            end
            ST_STEP: begin
                if (fetch_done) r_d.state = eff_lvl ? ST_RUN : ST_HALTED;
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_RUN, lvl_lat: 1'b1};
        else        r_q <= r_d;
    end

    assign halted = (r_q.state == ST_HALTED);
endmodule

// File: rtl/shc_mux.sv
module shc_mux #(
    parameter int ADDR_W = 12
) (
    input  logic              sel_pc,
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [ADDR_W-1:0] core_addr,
    output logic [ADDR_W-1:0] disp_addr
);
    always_comb begin
        disp_addr = sel_pc ? pc_next : core_addr;
    end
endmodule

// File: rtl/step_halt_ctrl.sv
module step_halt_ctrl #(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_n,
    input  logic              cyc_strobe,
    input  logic              fetch_done,
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [ADDR_W-1:0] core_addr,
    output logic              stall,
    output logic [ADDR_W-1:0] disp_addr
);
    logic ss_lvl;
    logic halted;

    shc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (step_n),
        .dout (ss_lvl)
    );

    shc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (ss_lvl),
        .strobe    (cyc_strobe),
        .fetch_done(fetch_done),
        .halted    (halted)
    );

    shc_mux #(.ADDR_W(ADDR_W)) u_mux (
        .sel_pc   (halted),
        .pc_next  (pc_next),
        .core_addr(core_addr),
        .disp_addr(disp_addr)
    );

    assign stall = halted;
endmodule

// File: rtl/step_halt_chk.sv
module step_halt_chk (
    input logic clk,
    input logic rst_n,
    input logic step_n,
    input logic cyc_strobe,
    input logic fetch_done,
    input logic stall,
    input logic ss_lvl
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R2: synchronized level lags the raw input by two edges
    p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (ss_lvl == $past(step_n, 2)));

    // R3: with no strobe and no fetch, stall cannot move
    p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_strobe && !fetch_done) |=> $stable(stall));

    // R5: stall only rises after a fetch-done cycle
    p_halt_after_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(fetch_done));

    // R8: stall only falls after a high level sampled under the strobe
    p_release_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> ($past(cyc_strobe) && $past(ss_lvl)));
endmodule

bind step_halt_ctrl step_halt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_n    (step_n),
    .cyc_strobe(cyc_strobe),
    .fetch_done(fetch_done),
    .stall     (stall),
    .ss_lvl    (ss_lvl)
);

// File: tb/step_halt_ctrl_bench.sv
module step_halt_ctrl_bench;
    localparam int CLK_P  = 10;
    localparam int AW     = 12;
    localparam logic [AW-1:0] PCV  = 12'hA5C;
    localparam logic [AW-1:0] CORE = 12'h3F1;
    localparam int NV = 34;
    // each entry: {step_n, cyc_strobe, fetch_done, expected stall}
    localparam logic [3:0] VEC [0:NV-1] = '{
        4'b0100, // 0  R2: raw low not yet visible under strobe
        4'b0100, // 1  R2
        4'b0010, // 2  R3 R11: strobe low, fetch ignored
        4'b0100, // 3  R4: pending
        4'b0000, // 4  R4
        4'b0011, // 5  R5: halt after fetch
        4'b1001, // 6  R3
        4'b1001, // 7  R3: high level without strobe ignored
        4'b0001, // 8
        4'b0100, // 9  R8: release
        4'b0000, // 10 R9
        4'b0100, // 11 R9: strobe captures low
        4'b0011, // 12 R9: one fetch then halt again
        4'b1001, // 13
        4'b1001, // 14
        4'b1110, // 15 R8: fetch ignored while halted, release
        4'b1110, // 16 R9: same-cycle strobe high -> run
        4'b1000, // 17
        4'b0000, // 18
        4'b0000, // 19
        4'b0100, // 20 R4
        4'b1000, // 21
        4'b1000, // 22
        4'b1100, // 23 R6: pending withdrawn
        4'b1010, // 24 R6 R11: fetch no longer halts
        4'b0000, // 25
        4'b0000, // 26
        4'b0100, // 27 R4
        4'b1000, // 28
        4'b1000, // 29
        4'b1111, // 30 R7: fetch beats release
        4'b1001, // 31
        4'b1100, // 32 R8
        4'b1010  // 33 R9: latched high level -> run
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic step_n = 1'b1, cyc_strobe = 1'b0, fetch_done = 1'b0;
    logic stall;
    logic [AW-1:0] disp_addr;
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    step_halt_ctrl #(.ADDR_W(AW)) u_step_halt_ctrl (
        .clk(clk), .rst_n(rst_n), .step_n(step_n), .cyc_strobe(cyc_strobe),
        .fetch_done(fetch_done), .pc_next(PCV), .core_addr(CORE),
        .stall(stall), .disp_addr(disp_addr)
    );

    task automatic check_out(input logic exp_stall, input string tag);
        logic [AW-1:0] exp_a;
        exp_a = exp_stall ? PCV : CORE;
        checks++;
        if (stall !== exp_stall) begin
            errors++;
            $display("FAIL %s stall actual=%0b expected=%0b", tag, stall, exp_stall);
        end
        checks++;
        if (disp_addr !== exp_a) begin
            errors++;
            $display("FAIL R10 %s disp_addr actual=%h expected=%h", tag, disp_addr, exp_a);
        end
    endtask

    task automatic row(input logic s, input logic a, input logic f);
        step_n = s; cyc_strobe = a; fetch_done = f;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out(1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_out(1'b0, "R1 after reset");

        for (int i = 0; i < NV; i++) begin
            row(VEC[i][3], VEC[i][2], VEC[i][1]);
            check_out(VEC[i][0], $sformatf("table row %0d (R2 R3 R4 R5 R6 R7 R8 R9 R11)", i));
        end

        // R1: reset while halted returns to free running
        row(1'b0, 1'b0, 1'b0);
        row(1'b0, 1'b0, 1'b0);
        row(1'b0, 1'b1, 1'b0);
        row(1'b0, 1'b0, 1'b1);
        check_out(1'b1, "R5 halted before reset");
        rst_n = 1'b0;
        #1;
        check_out(1'b0, "R1 reset while halted");
        @(negedge clk);
        rst_n = 1'b1;
        // R2: synchronizer restarts high, so low step under strobe is not seen at once
        row(1'b0, 1'b1, 1'b0);
        check_out(1'b0, "R2 after reset sync");
        row(1'b0, 1'b1, 1'b1);
        check_out(1'b0, "R2 R11 second edge");
        row(1'b0, 1'b1, 1'b0);
        check_out(1'b0, "R4 pending");
        row(1'b0, 1'b0, 1'b1);
        check_out(1'b1, "R5 halt");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule